// File: doc/BRIEF.md
# Strobed Input Handshake Controller

This block implements the handshake side of an 8-bit parallel input port. A peripheral drives data onto the port pins and pulses an active-low strobe. The strobe reaches the block asynchronously to the system clock. The block latches the pins when the strobe ends. It raises a "buffer full" flag toward the peripheral when the strobe begins. When the strobe ends it raises an interrupt request toward the CPU, which is gated by an enable bit the CPU controls.

The CPU reaches the block through a small synchronous access port. Each access is a one-cycle completion pulse carrying an address, a write flag and write data; `rd_data_o` decodes combinationally from the address. The address map is as follows:

- Addresses with the top two bits zero are single-bit operations:
  - address bits 2:0 select the bit;
  - bit 3 selects the data port (0) or the handshake port (1);
  - bit 4 selects set (1) or clear (0) on writes.
- Address 0x20 is the data port as a byte.
- Address 0x21 is the handshake port as a byte.
- Address 0x28 is the mode register.

On the handshake port, bit 6 is the buffer-full flag and bit 7 carries the strobe input, the interrupt-enable latch and the interrupt status. Reading the data port as a byte consumes the data and clears both flags.

Top module: `strobe_in_handshake`

## Requirements
- R1: After a synchronous reset the following hold: `ibf_o`=0, `intr_o`=0, the mode is basic (not strobed input) and the interrupt enable is 0.
- R2: The port is in strobed-input mode only when a mode-register write (address 0x28) carries data bit 5 = 1 and bit 6 = 0. Any mode-register write clears both the buffer-full flag and the interrupt request latch.
- R3: In strobed-input mode, a falling edge of `stb_n_i` sets `ibf_o`. The flag is visible at the third rising clock edge after the pin changes, because of the two-stage synchronizer plus edge register.
- R4: In strobed-input mode, a rising edge of `stb_n_i` latches `porta_pins_i` into the input latch and sets the interrupt request latch, with the same latency as R3. After several strobes the latch holds the data of the last one.
- R5: `intr_o` equals the interrupt request latch ANDed with the interrupt-enable bit. A write to 0x1F sets the enable bit and a write to 0x0F clears it.
- R6: In strobed-input mode, a byte read of 0x20 returns the input latch on `rd_data_o`. On completion of that read, the buffer-full flag and the interrupt request latch clear.
- R7: The handshake status and the input latch are left unchanged by the following accesses:
  - byte writes to 0x20;
  - any bit set, clear or read on the data port;
  - byte reads or writes of 0x21;
  - bit operations on handshake-port bits 0 to 5.
- R8: A write to 0x1E sets the buffer-full flag and a write to 0x0E clears it.
- R9: A bit read returns the selected bit on `rd_data_o` bit 7, with bits 6:0 zero. On the data port the selected bit comes from the byte the port reads. On the handshake port, bit 7 reads the interrupt request latch and bit 6 reads the buffer-full flag.
- R10: When a strobe edge and a byte-read completion of 0x20 act in the same clock, the strobe wins. A falling edge leaves `ibf_o` set, and a rising edge leaves the interrupt request latch set.
- R11: Outside strobed-input mode, strobes have no effect and `ibf_o` and `intr_o` stay low. A byte read of 0x20 returns `porta_pins_i` live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stb_n_i | input | 1 | Asynchronous active-low peripheral strobe |
| porta_pins_i | input | 8 | Data port pin values |
| acc_valid_i | input | 1 | One-cycle CPU access completion pulse |
| acc_wr_i | input | 1 | Access is a write (1) or a read (0) |
| acc_addr_i | input | 7 | Access address |
| acc_wdata_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data decoded from `acc_addr_i` |
| ibf_o | output | 1 | Buffer-full flag toward the peripheral |
| intr_o | output | 1 | Interrupt request toward the CPU |

## Verification
All 256 data values are strobed through the latch. Between the strobe and the read the pins are driven to the complement, so a read that returned the live pins instead of the latch would show. Each transfer checks the flags after the falling edge, after the rising edge and after the read. Separately, a strobe edge is made to land in the same clock as a byte read, once for each edge polarity. All eight settings of the mode field are swept to separate the one strobed-input encoding from the rest. Every address outside the handshake bits is hit while both flags are pending, to show which accesses must leave the status untouched.

// File: rtl/sih_pkg.sv
package sih_pkg;
    localparam int PORT_W      = 8;
    localparam int BIT_W       = $clog2(PORT_W);
    localparam int ADDR_W      = BIT_W + 4;
    localparam int FLAG_BIT    = PORT_W - 2;
    localparam int STROBE_BIT  = PORT_W - 1;

    localparam logic [ADDR_W-1:0] ADDR_DATA_BYTE = ADDR_W'(1) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] ADDR_HS_BYTE   = ADDR_DATA_BYTE | ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_MODE      = ADDR_DATA_BYTE | (ADDR_W'(1) << BIT_W);

    typedef struct packed {
        logic fall;
        logic rise;
    } stb_evt_t;

    typedef struct packed {
        logic       mode_wr;
        logic [1:0] mode_sel;
        logic       data_rd;
        logic       flag_set;
        logic       flag_clr;
        logic       ie_set;
        logic       ie_clr;
    } hs_cmd_t;

    function automatic logic is_bit_op(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:ADDR_W-2] == 2'b00;
    endfunction

    function automatic logic sel_is_strobed_in(input logic [1:0] m);
        return m == 2'b01;
    endfunction
endpackage

// File: rtl/sih_stb_sync.sv
module sih_stb_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stb_n_async,
    output sih_pkg::stb_evt_t  evt
);
    logic [STAGES-1:0] chain;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b1;
                    else     chain[0] <= stb_n_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b1;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b1;
        else     last_q <= chain[STAGES-1];
    end

    always_comb begin
        evt.fall = last_q & ~chain[STAGES-1];
        evt.rise = ~last_q & chain[STAGES-1];
    end
endmodule

// File: rtl/sih_cpu_decode.sv
module sih_cpu_decode
    import sih_pkg::*;
(
    input  logic              acc_valid,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [PORT_W-1:0] acc_wdata,
    input  logic [PORT_W-1:0] data_view,
    input  logic              flag_q,
    input  logic              irq_q,
    output hs_cmd_t           cmd,
    output logic [PORT_W-1:0] rd_data
);
    logic [BIT_W-1:0] bit_idx;
    logic             on_hs_port;
    logic             do_set;
    logic             bit_op;
    logic             sel_bit;
    logic             unused_wdata_bits;

    assign bit_idx    = acc_addr[BIT_W-1:0];
    assign on_hs_port = acc_addr[BIT_W];
    assign do_set     = acc_addr[BIT_W+1];
    assign bit_op     = is_bit_op(acc_addr);
    assign unused_wdata_bits = ^{acc_wdata[PORT_W-1], acc_wdata[PORT_W-4:0]};

    always_comb begin
        sel_bit = 1'b0;
        if (on_hs_port) begin
            if (bit_idx == BIT_W'(STROBE_BIT))    sel_bit = irq_q;
            else if (bit_idx == BIT_W'(FLAG_BIT)) sel_bit = flag_q;
        end else begin
            sel_bit = data_view[bit_idx];
        end
    end

    always_comb begin
        rd_data = '0;
        if (bit_op)                          rd_data[PORT_W-1] = sel_bit;
        else if (acc_addr == ADDR_DATA_BYTE) rd_data = data_view;
    end

    always_comb begin
        cmd = '0;
        if (acc_valid) begin
            if (acc_wr) begin
                if (bit_op && on_hs_port && bit_idx == BIT_W'(FLAG_BIT)) begin
                    cmd.flag_set = do_set;
                    cmd.flag_clr = ~do_set;
                end
                if (bit_op && on_hs_port && bit_idx == BIT_W'(STROBE_BIT)) begin
                    cmd.ie_set = do_set;
                    cmd.ie_clr = ~do_set;
                end
                if (acc_addr == ADDR_MODE) begin
                    cmd.mode_wr  = 1'b1;
                    cmd.mode_sel = acc_wdata[PORT_W-2:PORT_W-3];
                end
            end else if (acc_addr == ADDR_DATA_BYTE) begin
                cmd.data_rd = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sih_flags.sv
module sih_flags
    import sih_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hs_cmd_t  cmd,
    input  stb_evt_t evt,
    output logic     strobed_q,
    output logic     flag_q,
    output logic     irq_q,
    output logic     ie_q
);
    logic [1:0] mode_q;
    logic       flag_d;
    logic       irq_d;

    assign strobed_q = sel_is_strobed_in(mode_q);

    always_comb begin
        flag_d = flag_q;
        irq_d  = irq_q;
        if (cmd.mode_wr || !strobed_q) begin
            flag_d = 1'b0;
            irq_d  = 1'b0;
        end else begin
            if (cmd.data_rd)  begin flag_d = 1'b0; irq_d = 1'b0; end
            if (cmd.flag_set) flag_d = 1'b1;
            if (cmd.flag_clr) flag_d = 1'b0;
            if (evt.fall)     flag_d = 1'b1;
            if (evt.rise)     irq_d  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 2'b00;
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
            ie_q   <= 1'b0;
        end else begin
            if (cmd.mode_wr) mode_q <= cmd.mode_sel;
            if (cmd.ie_set)      ie_q <= 1'b1;
            else if (cmd.ie_clr) ie_q <= 1'b0;
            flag_q <= flag_d;
            irq_q  <= irq_d;
        end
    end

    assert_fall_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
        (strobed_q && evt.fall && !cmd.mode_wr) |=> flag_q);

    assert_rise_sets_irq_R4: assert property (@(posedge clk) disable iff (rst)
        (strobed_q && evt.rise && !cmd.mode_wr) |=> irq_q);

    assert_read_clears_irq_R6: assert property (@(posedge clk) disable iff (rst)
        (strobed_q && cmd.data_rd && !evt.rise && !cmd.mode_wr) |=> !irq_q);

    assert_mode_write_init_R2: assert property (@(posedge clk) disable iff (rst)
        cmd.mode_wr |=> (!flag_q && !irq_q));

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (rst)
        cmd.ie_set |=> ie_q);

    assert_basic_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (!strobed_q && !cmd.mode_wr) |=> (!flag_q && !irq_q));
endmodule

// File: rtl/sih_capture.sv
module sih_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         rise,
    input  logic [W-1:0] pins,
    output logic [W-1:0] latch_q
);
    always_ff @(posedge clk) begin
        if (rst)                 latch_q <= '0;
        else if (enable && rise) latch_q <= pins;
    end

    assert_capture_value_R4: assert property (@(posedge clk) disable iff (rst)
        (enable && rise) |=> (latch_q == $past(pins)));

    assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !(enable && rise) |=> $stable(latch_q));
endmodule

// File: rtl/strobe_in_handshake.sv
module strobe_in_handshake
    import sih_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stb_n_i,
    input  logic [PORT_W-1:0] porta_pins_i,
    input  logic              acc_valid_i,
    input  logic              acc_wr_i,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic [PORT_W-1:0] acc_wdata_i,
    output logic [PORT_W-1:0] rd_data_o,
    output logic              ibf_o,
    output logic              intr_o
);
    stb_evt_t          evt;
    hs_cmd_t           cmd;
    logic              strobed_q;
    logic              flag_q;
    logic              irq_q;
    logic              ie_q;
    logic [PORT_W-1:0] latch_q;
    logic [PORT_W-1:0] data_view;

    sih_stb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .stb_n_async (stb_n_i),
        .evt         (evt)
    );

    sih_capture #(.W(PORT_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .enable  (strobed_q),
        .rise    (evt.rise),
        .pins    (porta_pins_i),
        .latch_q (latch_q)
    );

    assign data_view = strobed_q ? latch_q : porta_pins_i;

    sih_cpu_decode u_dec (
        .acc_valid (acc_valid_i),
        .acc_wr    (acc_wr_i),
        .acc_addr  (acc_addr_i),
        .acc_wdata (acc_wdata_i),
        .data_view (data_view),
        .flag_q    (flag_q),
        .irq_q     (irq_q),
        .cmd       (cmd),
        .rd_data   (rd_data_o)
    );

    sih_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd),
        .evt       (evt),
        .strobed_q (strobed_q),
        .flag_q    (flag_q),
        .irq_q     (irq_q),
        .ie_q      (ie_q)
    );

    assign ibf_o  = flag_q;
    assign intr_o = irq_q & ie_q;

    assert_intr_needs_irq_R5: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> $past(irq_q || evt.rise));
endmodule

// File: tb/tb_strobe_in_handshake.sv
module tb_strobe_in_handshake;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       stb_n = 1'b1;
    logic [7:0] pins = 8'h00;
    logic       acc_valid = 1'b0;
    logic       acc_wr = 1'b0;
    logic [6:0] acc_addr = 7'h00;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] rd_data;
    logic       ibf;
    logic       intr;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    strobe_in_handshake dut (
        .clk(clk), .rst(rst), .stb_n_i(stb_n), .porta_pins_i(pins),
        .acc_valid_i(acc_valid), .acc_wr_i(acc_wr), .acc_addr_i(acc_addr),
        .acc_wdata_i(acc_wdata), .rd_data_o(rd_data), .ibf_o(ibf), .intr_o(intr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_wr = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_wr = 1'b0; acc_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic stb_fall();
        @(negedge clk);
        stb_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic stb_rise(input logic [7:0] v);
        @(negedge clk);
        pins = v; stb_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic flags(input string req, input logic e_ibf, input logic e_intr);
        check({req, " ibf"}, {7'd0, ibf}, {7'd0, e_ibf});
        check({req, " intr"}, {7'd0, intr}, {7'd0, e_intr});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        flags("R1", 1'b0, 1'b0);
        pins = 8'hA5;
        rd(7'h20, d); check("R1 basic byte read", d, 8'hA5);

        // R11: basic mode ignores strobes, live pins on byte read
        wr(7'h1F, 8'h00);
        stb_fall(); flags("R11", 1'b0, 1'b0);
        stb_rise(8'h3C); flags("R11", 1'b0, 1'b0);
        pins = 8'h5A;
        rd(7'h20, d); check("R11 live pins", d, 8'h5A);
        rd(7'h0F, d); check("R11 bit read irq", d, 8'h00);

        // R2: mode sweep, only bits 6:5 = 01 selects strobed input
        for (int m = 0; m < 8; m++) begin
            wr(7'h28, 8'(m << 5));
            flags("R2 after mode write", 1'b0, 1'b0);
            stb_fall();
            check("R2 mode select", {7'd0, ibf}, {7'd0, ((m & 3) == 1) ? 1'b1 : 1'b0});
            stb_rise(8'h00);
        end
        wr(7'h28, 8'h20);
        flags("R2 init", 1'b0, 1'b0);

        // R3 R4 R5 R6: every data value through the latch
        for (int v2 = 0; v2 < 256; v2++) begin
            pins = 8'(~v2);
            stb_fall(); flags("R3", 1'b1, 1'b0);
            stb_rise(8'(v2)); flags("R4", 1'b1, 1'b1);
            pins = 8'(~v2);
            rd(7'h20, d); check("R6 byte read", d, 8'(v2));
            flags("R6 cleared", 1'b0, 1'b0);
        end

        // R4: last of several strobes is kept
        stb_fall(); stb_rise(8'h11);
        stb_fall(); stb_rise(8'h22);
        rd(7'h20, d); check("R4 last strobe", d, 8'h22);

        // R5 R9: enable gating and status bit reads
        wr(7'h0F, 8'hFF);
        stb_fall(); stb_rise(8'h96);
        flags("R5 disabled", 1'b1, 1'b0);
        rd(7'h0F, d); check("R9 irq bit read", d, 8'h80);
        rd(7'h1E, d); check("R9 flag bit read", d, 8'h80);
        wr(7'h1F, 8'h00);
        flags("R5 enabled", 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            v = 8'h96;
            rd(7'(i), d); check("R9 data bit read", d, {v[i], 7'd0});
            rd(7'(16 + i), d); check("R9 data bit read a4", d, {v[i], 7'd0});
        end

        // R7: accesses that must not disturb status or latch
        wr(7'h20, 8'h00); flags("R7 byte write A", 1'b1, 1'b1);
        wr(7'h21, 8'hFF); flags("R7 byte write B", 1'b1, 1'b1);
        rd(7'h21, d);     flags("R7 byte read B", 1'b1, 1'b1);
        for (int a = 0; a < 32; a++) begin
            if ((a & 8) == 0 || (a & 7) < 6) begin
                wr(7'(a), 8'h00);
                flags("R7 bit op", 1'b1, 1'b1);
            end
        end
        rd(7'h20, d); check("R7 latch kept", d, 8'h96);
        flags("R6 clear", 1'b0, 1'b0);

        // R8: flag override
        wr(7'h1E, 8'h00); flags("R8 set", 1'b1, 1'b0);
        wr(7'h0E, 8'hFF); flags("R8 clear", 1'b0, 1'b0);

        // R10: rising edge coincident with byte read
        stb_fall();
        @(negedge clk); pins = 8'h4D; stb_n = 1'b1;
        @(negedge clk);
        @(negedge clk); acc_valid = 1'b1; acc_wr = 1'b0; acc_addr = 7'h20;
        @(negedge clk); acc_valid = 1'b0;
        flags("R10 rise wins", 1'b0, 1'b1);
        rd(7'h20, d); check("R10 data", d, 8'h4D);
        flags("R10 consumed", 1'b0, 1'b0);

        // R10: falling edge coincident with byte read
        @(negedge clk); stb_n = 1'b0;
        @(negedge clk);
        @(negedge clk); acc_valid = 1'b1; acc_wr = 1'b0; acc_addr = 7'h20;
        @(negedge clk); acc_valid = 1'b0;
        flags("R10 fall wins", 1'b1, 1'b0);
        stb_rise(8'h77);

        // R2: mode write clears pending flags
        flags("R2 pending", 1'b1, 1'b1);
        wr(7'h28, 8'h20);
        flags("R2 clears", 1'b0, 1'b0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule